// File: doc/BRIEF.md
# Low-Speed USB Line State and Bus Event Detector

This block sits behind the two single-ended data pins of a low-speed USB port. Its sampling clock runs at several times the 1.5 Mbit/s bit rate, 12 MHz by default, which gives eight samples per bit. Both pins first pass through a synchroniser. A two-sample agreement filter then removes single-sample glitches. The filtered pair is reported as one of four bus states, using low-speed polarity, where the idle line has D- high.

Two run timers measure how long the line has stayed in single-ended zero and how long it has stayed idle. These durations, together with state transitions, produce one-cycle strobes for start of packet, end of packet, connect, disconnect and bus reset. All microsecond thresholds are computed from the clock frequency parameter. Bit-time thresholds are computed from the ratio of clock rate to bit rate.

Top module: `usb_ls_line_monitor`

## Requirements
- R1: `line_state` carries the filtered pair as {D+, D-}: 2'b00 single-ended zero, 2'b01 J (idle, D- high), 2'b10 K, 2'b11 single-ended one. A change that is held at the pins shows on `line_state` four clock edges after it is applied (two synchroniser stages plus two agreeing samples). Reset leaves `line_state` at 2'b00.
- R2: `se1_err` is high in exactly those cycles in which `line_state` is single-ended one.
- R3: A pin change that lasts a single sample never reaches `line_state`.
- R4: `sop_pulse` is high for one cycle, in the first K cycle that directly follows a J cycle, and only while the detector is armed. Arming is cleared by that strobe, so later J-to-K transitions inside the packet give no strobe.
- R5: `disconnect_pulse` is high in the 24th consecutive single-ended-zero cycle (2 µs at 12 MHz).
- R6: `bus_reset_pulse` is high in the 30th consecutive single-ended-zero cycle (2.5 µs at 12 MHz).
- R7: `eop_pulse` is high in the 8th consecutive J cycle (one bit time) when the run directly before that J run was single-ended zero lasting 12 to 23 cycles. A shorter or longer single-ended-zero run gives no end-of-packet strobe.
- R8: `connect_pulse` is high in the 30th consecutive J cycle (2.5 µs), but only while the port is detached. A connect strobe attaches the port and a disconnect strobe detaches it. The port starts out detached after reset.
- R9: An end-of-packet strobe arms start-of-packet detection. A disconnect or bus reset disarms it until the line has next shown J, and the first J after reset also arms it.
- R10: Each run timer restarts when the line leaves the state it measures. Two 20-cycle single-ended-zero runs separated by a short J run therefore give no disconnect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (default 12 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_in | input | 1 | D+ pin level, asynchronous |
| dm_in | input | 1 | D- pin level, asynchronous |
| line_state | output | 2 | Filtered bus state {D+, D-} |
| se1_err | output | 1 | Illegal single-ended-one state present |
| sop_pulse | output | 1 | Start-of-packet strobe |
| eop_pulse | output | 1 | End-of-packet strobe |
| connect_pulse | output | 1 | Connect strobe |
| disconnect_pulse | output | 1 | Disconnect strobe |
| bus_reset_pulse | output | 1 | Bus reset strobe |

## Verification
A filter or synchroniser fault shows on `line_state` within four edges of the pin change that exposes it. Such a fault also shifts every run length by which the strobes are timed. A run counter that fails to clear, or that counts one too far, moves a disconnect, bus reset, connect or end-of-packet strobe by one cycle, or removes it. The per-cycle comparison shows that at once. A corrupt arming or attach flag stays invisible until the next packet start or the next long idle run. It then surfaces as a missing or extra start-of-packet or connect strobe. The scenarios are therefore ordered so that each flag is exercised after every event that changes it.

// File: rtl/usb_ls_pkg.sv
package usb_ls_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_e;

   // number of sampling-clock cycles covering a duration given in nanoseconds
   function automatic int ns_to_cycles(input int clk_hz, input int dur_ns);
      return (clk_hz / 1000) * dur_ns / 1_000_000;
   endfunction

endpackage

// File: rtl/usb_ls_sync.sv
module usb_ls_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);

   logic [W-1:0] chain_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("usb_ls_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= '0;
               else        chain_q[i] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= '0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/usb_ls_deglitch.sv
module usb_ls_deglitch #(
   parameter bit FILTER_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          raw,
   output usb_ls_pkg::line_e   line_q
);
   import usb_ls_pkg::*;

   generate
      if (FILTER_EN) begin : g_filter
         logic [1:0] last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q <= 2'b00;
               line_q <= LS_SE0;
            end else begin
               last_q <= raw;
               if (raw == last_q) line_q <= line_e'(raw);
            end
         end
      end else begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= LS_SE0;
            else        line_q <= line_e'(raw);
         end
      end
   endgenerate

endmodule

// File: rtl/usb_ls_run_timer.sv
module usb_ls_run_timer #(
   parameter int              W      = 5,
   parameter int              NHIT   = 2,
   parameter logic [NHIT*16-1:0] HIT_AT = {16'd30, 16'd24}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   output logic [W-1:0]    count_o,
   output logic [NHIT-1:0] hits
);

   localparam logic [W-1:0] CMAX = '1;

   // count_o is the number of earlier cycles of the current run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count_o <= '0;
      else if (!active)        count_o <= '0;
      else if (count_o != CMAX) count_o <= count_o + 1'b1;
   end

   generate
      for (genvar i = 0; i < NHIT; i++) begin : g_hit
         localparam int THR = int'(HIT_AT[i*16 +: 16]);
         if (THR < 1 || THR > (1 << W) - 1) begin : g_bad_thr
            $error("usb_ls_run_timer: threshold out of counter range");
         end
         assign hits[i] = active && (count_o == W'(THR - 1));
      end
   endgenerate

endmodule

// File: rtl/usb_ls_events.sv
module usb_ls_events #(
   parameter int W           = 5,
   parameter int EOP_SE0_MIN = 12,
   parameter int EOP_SE0_MAX = 23,
   parameter int EOP_J_CYC   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  usb_ls_pkg::line_e line_i,
   input  logic [W-1:0]      se0_cnt,
   input  logic [W-1:0]      idle_cnt,
   input  logic              se0_disc_hit,
   input  logic              se0_rst_hit,
   input  logic              idle_conn_hit,
   output logic              sop_o,
   output logic              eop_o,
   output logic              conn_o,
   output logic              disc_o,
   output logic              busrst_o
);
   import usb_ls_pkg::*;

   generate
      if (EOP_J_CYC < 2) begin : g_bad_eopj
         $error("usb_ls_events: J hold for end of packet must be at least 2 cycles");
      end
      if (EOP_SE0_MIN > EOP_SE0_MAX) begin : g_bad_window
         $error("usb_ls_events: empty end-of-packet window");
      end
   endgenerate

   line_e prev_q;
   logic  armed_q, rearm_q, attached_q, eop_wait_q;
   logic  eop_open;

   // first J cycle after a single-ended-zero run of acceptable length
   assign eop_open = (line_i == LS_J) && (prev_q == LS_SE0) &&
                     (se0_cnt >= W'(EOP_SE0_MIN)) && (se0_cnt <= W'(EOP_SE0_MAX));

   assign sop_o    = armed_q && (line_i == LS_K) && (prev_q == LS_J);
   assign eop_o    = eop_wait_q && (line_i == LS_J) && (idle_cnt == W'(EOP_J_CYC - 1));
   assign conn_o   = idle_conn_hit && !attached_q;
   assign disc_o   = se0_disc_hit;
   assign busrst_o = se0_rst_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= LS_SE0;
         eop_wait_q <= 1'b0;
      end else begin
         prev_q <= line_i;
         if (line_i != LS_J)  eop_wait_q <= 1'b0;
         else if (eop_open)   eop_wait_q <= 1'b1;
         else if (eop_o)      eop_wait_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         rearm_q <= 1'b1;
      end else if (disc_o || busrst_o) begin
         armed_q <= 1'b0;
         rearm_q <= 1'b1;
      end else if (sop_o) begin
         armed_q <= 1'b0;
      end else if (eop_o) begin
         armed_q <= 1'b1;
      end else if (rearm_q && line_i == LS_J) begin
         armed_q <= 1'b1;
         rearm_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      attached_q <= 1'b0;
      else if (conn_o) attached_q <= 1'b1;
      else if (disc_o) attached_q <= 1'b0;
   end

endmodule

// File: rtl/usb_ls_line_monitor.sv
module usb_ls_line_monitor #(
   parameter int CLK_HZ      = 12_000_000,
   parameter int BIT_HZ      = 1_500_000,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dp_in,
   input  logic       dm_in,
   output logic [1:0] line_state,
   output logic       se1_err,
   output logic       sop_pulse,
   output logic       eop_pulse,
   output logic       connect_pulse,
   output logic       disconnect_pulse,
   output logic       bus_reset_pulse
);
   import usb_ls_pkg::*;

   localparam int SPB         = CLK_HZ / BIT_HZ;
   localparam int DISC_CYC    = ns_to_cycles(CLK_HZ, 2000);
   localparam int RST_CYC     = ns_to_cycles(CLK_HZ, 2500);
   localparam int CONN_CYC    = ns_to_cycles(CLK_HZ, 2500);
   localparam int EOP_SE0_MIN = SPB + SPB / 2;
   localparam int EOP_SE0_MAX = DISC_CYC - 1;
   localparam int EOP_J_CYC   = SPB;
   localparam int TMAX        = (RST_CYC > CONN_CYC) ? RST_CYC : CONN_CYC;
   localparam int TW          = $clog2(TMAX + 1);

   generate
      if (SPB < 4) begin : g_bad_ratio
         $error("usb_ls_line_monitor: need at least 4 samples per bit");
      end
      if (RST_CYC <= DISC_CYC) begin : g_bad_order
         $error("usb_ls_line_monitor: reset threshold must exceed disconnect threshold");
      end
      if (CONN_CYC <= EOP_J_CYC) begin : g_bad_conn
         $error("usb_ls_line_monitor: connect threshold must exceed end-of-packet J hold");
      end
   endgenerate

   logic [1:0]  raw_sync;
   line_e       line_q;
   logic [TW-1:0] se0_cnt, idle_cnt;
   logic [1:0]  se0_hits;
   logic [0:0]  idle_hits;

   usb_ls_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({dp_in, dm_in}),
      .q_out (raw_sync)
   );

   usb_ls_deglitch #(.FILTER_EN(FILTER_EN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_sync),
      .line_q (line_q)
   );

   usb_ls_run_timer #(
      .W      (TW),
      .NHIT   (2),
      .HIT_AT ({16'(RST_CYC), 16'(DISC_CYC)})
   ) u_se0_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (line_q == LS_SE0),
      .count_o (se0_cnt),
      .hits    (se0_hits)
   );

   usb_ls_run_timer #(
      .W      (TW),
      .NHIT   (1),
      .HIT_AT (16'(CONN_CYC))
   ) u_idle_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (line_q == LS_J),
      .count_o (idle_cnt),
      .hits    (idle_hits)
   );

   usb_ls_events #(
      .W           (TW),
      .EOP_SE0_MIN (EOP_SE0_MIN),
      .EOP_SE0_MAX (EOP_SE0_MAX),
      .EOP_J_CYC   (EOP_J_CYC)
   ) u_events (
      .clk           (clk),
      .rst_n         (rst_n),
      .line_i        (line_q),
      .se0_cnt       (se0_cnt),
      .idle_cnt      (idle_cnt),
      .se0_disc_hit  (se0_hits[0]),
      .se0_rst_hit   (se0_hits[1]),
      .idle_conn_hit (idle_hits[0]),
      .sop_o         (sop_pulse),
      .eop_o         (eop_pulse),
      .conn_o        (connect_pulse),
      .disc_o        (disconnect_pulse),
      .busrst_o      (bus_reset_pulse)
   );

   assign line_state = line_q;
   assign se1_err    = (line_q == LS_SE1);

endmodule

// File: rtl/usb_ls_line_monitor_chk.sv
module usb_ls_line_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] line_state,
   input logic       se1_err,
   input logic       sop_pulse,
   input logic       eop_pulse,
   input logic       connect_pulse,
   input logic       disconnect_pulse,
   input logic       bus_reset_pulse
);

   assert_se1_no_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      se1_err |-> !(sop_pulse || eop_pulse || connect_pulse || disconnect_pulse || bus_reset_pulse));

   assert_sop_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sop_pulse |-> (line_state == 2'b10) && ($past(line_state) == 2'b01));

   assert_disc_in_se0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      disconnect_pulse |-> (line_state == 2'b00) && ($past(line_state) == 2'b00));

   assert_reset_in_se0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_pulse |-> (line_state == 2'b00) && ($past(line_state) == 2'b00));

   assert_eop_in_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eop_pulse |-> (line_state == 2'b01) && ($past(line_state) == 2'b01));

   assert_conn_in_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      connect_pulse |-> (line_state == 2'b01) && ($past(line_state) == 2'b01));

   assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sop_pulse, eop_pulse, connect_pulse, disconnect_pulse, bus_reset_pulse}));

endmodule

bind usb_ls_line_monitor usb_ls_line_monitor_chk u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .line_state       (line_state),
   .se1_err          (se1_err),
   .sop_pulse        (sop_pulse),
   .eop_pulse        (eop_pulse),
   .connect_pulse    (connect_pulse),
   .disconnect_pulse (disconnect_pulse),
   .bus_reset_pulse  (bus_reset_pulse)
);

// File: tb/usb_ls_line_monitor_tb.sv
module usb_ls_line_monitor_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dp = 1'b0, dm = 1'b0;
   logic [1:0] line_state;
   logic se1_err, sop, eop, conn, disc, brst;

   always #5 clk = ~clk;

   usb_ls_line_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .dp_in(dp), .dm_in(dm),
      .line_state(line_state), .se1_err(se1_err), .sop_pulse(sop),
      .eop_pulse(eop), .connect_pulse(conn), .disconnect_pulse(disc),
      .bus_reset_pulse(brst)
   );

   localparam logic [1:0] SE0 = 2'b00, JS = 2'b01, KS = 2'b10, SE1 = 2'b11;

   int errors = 0, checks = 0;
   bit done = 0;

   // behavioural reference model
   logic [1:0] hq[$];
   logic [1:0] m_line;
   int run, prev_state, prev_len;
   bit armed, rearm, attached;
   bit e_sop, e_eop, e_conn, e_disc, e_rst;

   always @(posedge clk) begin
      if (!rst_n) begin
         hq.delete();
         repeat (4) hq.push_front(2'b00);
         m_line = SE0; run = 1; prev_state = -1; prev_len = 0;
         armed = 0; rearm = 1; attached = 0;
         e_sop = 0; e_eop = 0; e_conn = 0; e_disc = 0; e_rst = 0;
      end else begin
         logic [1:0] old, nl;
         if (e_disc || e_rst) begin armed = 0; rearm = 1; end
         else if (e_sop) armed = 0;
         else if (e_eop) armed = 1;
         else if (rearm && m_line == JS) begin armed = 1; rearm = 0; end
         if (e_conn) attached = 1;
         else if (e_disc) attached = 0;
         hq.push_front({dp, dm});
         if (hq.size() > 6) void'(hq.pop_back());
         old = m_line;
         nl = (hq[2] == hq[3]) ? hq[2] : m_line;
         if (nl == old) run++;
         else begin prev_state = int'(old); prev_len = run; run = 1; end
         m_line = nl;
         e_disc = (m_line == SE0) && (run == 24);
         e_rst  = (m_line == SE0) && (run == 30);
         e_sop  = armed && (m_line == KS) && (old == JS);
         e_eop  = (m_line == JS) && (run == 8) && (prev_state == int'(SE0)) &&
                  (prev_len >= 12) && (prev_len <= 23);
         e_conn = (m_line == JS) && (run == 30) && !attached;
      end
   end

   int n_sop = 0, n_eop = 0, n_conn = 0, n_disc = 0, n_rst = 0;
   bit k_seen = 0, se1_seen = 0;

   task automatic cmp(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp("R1 line_state", int'(line_state), int'(m_line));
         cmp("R2 se1_err", int'(se1_err), int'(m_line == SE1));
         cmp("R4 sop_pulse", int'(sop), int'(e_sop));
         cmp("R5 disconnect_pulse", int'(disc), int'(e_disc));
         cmp("R6 bus_reset_pulse", int'(brst), int'(e_rst));
         cmp("R7 eop_pulse", int'(eop), int'(e_eop));
         cmp("R8 connect_pulse", int'(conn), int'(e_conn));
         n_sop += int'(sop); n_eop += int'(eop); n_conn += int'(conn);
         n_disc += int'(disc); n_rst += int'(brst);
         if (line_state == KS) k_seen = 1;
         if (se1_err) se1_seen = 1;
      end
   end

   task automatic hold(input logic [1:0] st, input int n);
      {dp, dm} = st;
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   int s_sop, s_eop, s_conn, s_disc, s_rst;
   task automatic snap();
      s_sop = n_sop; s_eop = n_eop; s_conn = n_conn; s_disc = n_disc; s_rst = n_rst;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // reset state
      cmp("R1 reset line_state", int'(line_state), 0);
      cmp("R1 reset strobes", int'({sop, eop, conn, disc, brst, se1_err}), 0);
      rst_n = 1'b1;

      // power-up idle: one connect, then no repeat
      snap();
      hold(JS, 40);
      cmp("R8 first connect", n_conn - s_conn, 1);
      cmp("R7 no eop on power-up", n_eop - s_eop, 0);
      hold(JS, 40);
      cmp("R8 no repeated connect", n_conn - s_conn, 1);

      // packet with a valid 16-cycle end marker
      snap();
      hold(KS, 8); hold(JS, 8); hold(KS, 8); hold(JS, 8);
      hold(KS, 8); hold(JS, 8); hold(KS, 16); hold(JS, 24); hold(KS, 8);
      hold(SE0, 16); hold(JS, 20);
      cmp("R4 one sop per packet", n_sop - s_sop, 1);
      cmp("R7 eop after 16 SE0", n_eop - s_eop, 1);

      // end marker too short (11 cycles)
      snap();
      hold(KS, 8); hold(JS, 8); hold(SE0, 11); hold(JS, 20);
      cmp("R4 sop after rearm by eop", n_sop - s_sop, 1);
      cmp("R7 no eop after 11 SE0", n_eop - s_eop, 0);

      // not armed, lower boundary 12 cycles
      snap();
      hold(KS, 8); hold(JS, 8); hold(SE0, 12); hold(JS, 20);
      cmp("R9 no sop while disarmed", n_sop - s_sop, 0);
      cmp("R7 eop after 12 SE0", n_eop - s_eop, 1);

      // single-sample glitch to K on idle
      snap(); k_seen = 0;
      hold(KS, 1); hold(JS, 20);
      cmp("R3 glitch never shown", int'(k_seen), 0);
      cmp("R3 glitch gives no sop", n_sop - s_sop, 0);

      // illegal state
      se1_seen = 0;
      hold(SE1, 6); hold(JS, 20);
      cmp("R2 se1 flagged", int'(se1_seen), 1);

      // timers restart between runs
      snap();
      hold(SE0, 20); hold(JS, 3); hold(SE0, 20); hold(JS, 20);
      cmp("R10 no disconnect from split SE0", n_disc - s_disc, 0);
      cmp("R10 eop after second run", n_eop - s_eop, 1);

      // long SE0 inside a packet, rearm on idle, reconnect
      snap();
      hold(KS, 8); hold(JS, 8); hold(SE0, 40); hold(JS, 10); hold(KS, 8); hold(JS, 40);
      cmp("R5 disconnect once", n_disc - s_disc, 1);
      cmp("R6 bus reset once", n_rst - s_rst, 1);
      cmp("R9 sop after idle following reset", n_sop - s_sop, 2);
      cmp("R8 reconnect after disconnect", n_conn - s_conn, 1);
      cmp("R7 no eop after long SE0", n_eop - s_eop, 0);

      // upper window edges
      snap();
      hold(SE0, 23); hold(JS, 20);
      cmp("R7 eop after 23 SE0", n_eop - s_eop, 1);
      cmp("R5 no disconnect at 23", n_disc - s_disc, 0);
      snap();
      hold(SE0, 24); hold(JS, 40);
      cmp("R7 no eop after 24 SE0", n_eop - s_eop, 0);
      cmp("R5 disconnect at 24", n_disc - s_disc, 1);
      cmp("R6 no reset at 24", n_rst - s_rst, 0);
      cmp("R8 connect after short detach", n_conn - s_conn, 1);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog (R1-R10 run) actual=timeout expected=finish");
         done = 1;
         summary();
         $finish;
      end
   end

endmodule